// File: doc/BRIEF.md
# PLL ratio control sequencer

This block is the register-side controller for a clock multiplier. It holds the multiply ratio code, the post-divider select and a watchdog enable. It also times the settling period that follows every ratio change. All logic runs on the oscillator clock. A write-protect enable input must be high for any register write to have an effect. The analog loop itself is outside the block. The output frequency is reported only as a multiply factor and a divisor: f_out = f_osc * mult_o / divisor_o.

Software changes the ratio in a fixed order:
1. Clear the watchdog enable.
2. Make sure the post-divider is in use, so the divisor is 2.
3. Write a new code.
4. Wait for the lock flag.
5. Optionally bypass the post-divider and re-enable the watchdog.

Writes that break this order are dropped, and a ratio write that is dropped raises a sticky error flag.

Top module: `pll_ratio_seq`

## Requirements
- R1: After reset the outputs are: ratio 0, bypass 1, lock 1, divider select 0, watchdog enable 1, error 0, multiply factor 1, divisor 2.
- R2: A write with prot_en_i low has no effect on any register and does not set the error flag.
- R3: A protected write to address 0 carrying a code from 0 to 10 in wr_data_i[3:0] is accepted when the divider select and the watchdog enable are both 0. ratio_o shows the new code one cycle later.
- R4: A protected write to address 0 with a reserved code (11 to 15) leaves the ratio unchanged and sets the error flag.
- R5: A protected ratio write is rejected while the divider select is 1 or the watchdog enable is 1. It leaves the ratio unchanged and sets the error flag.
- R6: Once set, the error flag stays at 1 until reset.
- R7: An accepted ratio write drives lock_o to 0 in the next cycle. lock_o returns to 1 exactly LOCK_CYCLES clock cycles after the edge that accepted the write (131072 by default).
- R8: An accepted ratio write made while a lock count is running restarts the count from zero.
- R9: A protected write to address 1 loads bit 0 into the divider select. Setting the bit to 1 is ignored while lock_o is 0. Clearing it is always accepted.
- R10: A protected write to address 1 loads bit 1 into the watchdog enable. Setting the bit to 1 is ignored while lock_o is 0. Clearing it is always accepted.
- R11: The decoded outputs follow the registers:
  - bypass_o is 1 exactly when the code is 0.
  - mult_o equals the code for codes 1 to 10, and 1 for code 0.
  - divisor_o is 2 while the divider select is 0, and 1 while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_en_i | input | 1 | Write-protect enable; writes take effect only while this is high |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Register select: 0 = ratio, 1 = control |
| wr_data_i | input | 4 | Write data: ratio code, or control bits {-, -, wdog, div} |
| ratio_o | output | 4 | Current ratio code |
| bypass_o | output | 1 | Multiplier bypassed (code 0) |
| lock_o | output | 1 | Lock time has elapsed since the last accepted ratio write |
| div_sel_o | output | 1 | Divider select: 1 bypasses the divide-by-two stage |
| wdog_en_o | output | 1 | Watchdog enable |
| err_o | output | 1 | Sticky error: a ratio write was rejected |
| mult_o | output | 4 | Effective multiply factor |
| divisor_o | output | 2 | Effective divisor n |

## Verification
Every register output changes one clock after the write strobe edge. The only exception is lock_o, which rises exactly LOCK_CYCLES edges after the accepting edge. The decoded outputs (mult_o, bypass_o, divisor_o) follow their registers within the same cycle. The bench drives its inputs and compares all outputs on the falling edge. Its reference model advances on the rising edge, so every comparison falls half a cycle after the edge that should have produced the expected value. A checker counts edges from each accepted write and requires any rise of lock_o to land on exactly that count.

// File: rtl/pll_ratio_pkg.sv
package pll_ratio_pkg;
  localparam int RATIO_W   = 4;
  localparam int MAX_CODE  = 10;
  localparam int DATA_W    = 4;
  localparam int DIVISOR_W = 2;
  localparam int CTRL_DIV  = 0;
  localparam int CTRL_WDOG = 1;

  typedef enum logic {
    ADDR_RATIO = 1'b0,
    ADDR_CTRL  = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/pll_lock_timer.sv
module pll_lock_timer #(
  parameter int LOCK_CYCLES = 131072
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic lock_o
);
  localparam int CNT_W = (LOCK_CYCLES > 2) ? $clog2(LOCK_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      lock_o <= 1'b1;
    end else if (start_i) begin
      // restart on every accepted write, even mid-count
      cnt_q  <= '0;
      busy_q <= 1'b1;
      lock_o <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        lock_o <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_ratio_regs.sv
module pll_ratio_regs
  import pll_ratio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prot_en_i,
  input  logic               wr_en_i,
  input  logic               wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               lock_i,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               div_sel_o,
  output logic               wdog_en_o,
  output logic               err_o,
  output logic               start_o
);
  localparam logic [RATIO_W-1:0] MAX_CODE_L = RATIO_W'(MAX_CODE);

  logic               wr_ratio, wr_ctrl, code_ok;
  logic [RATIO_W-1:0] code;
  logic               unused_hi;

  assign code      = wr_data_i[RATIO_W-1:0];
  assign unused_hi = ^wr_data_i[DATA_W-1:CTRL_WDOG+1];
  assign wr_ratio  = prot_en_i & wr_en_i & (wr_addr_i == ADDR_RATIO);
  assign wr_ctrl   = prot_en_i & wr_en_i & (wr_addr_i == ADDR_CTRL);
  assign code_ok   = code <= MAX_CODE_L;
  assign start_o   = wr_ratio & code_ok & ~div_sel_o & ~wdog_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ratio_o   <= '0;
      div_sel_o <= 1'b0;
      wdog_en_o <= 1'b1;
      err_o     <= 1'b0;
    end else begin
      if (start_o)             ratio_o <= code;
      if (wr_ratio & ~start_o) err_o   <= 1'b1;
      if (wr_ctrl) begin
        // setting either bit needs lock; clearing is free
        div_sel_o <= wr_data_i[CTRL_DIV]  & (lock_i | div_sel_o);
        wdog_en_o <= wr_data_i[CTRL_WDOG] & (lock_i | wdog_en_o);
      end
    end
  end
endmodule

// File: rtl/pll_ratio_decode.sv
module pll_ratio_decode
  import pll_ratio_pkg::*;
(
  input  logic                 [RATIO_W-1:0]   ratio_i,
  input  logic                                 div_sel_i,
  output logic                                 bypass_o,
  output logic                 [RATIO_W-1:0]   mult_o,
  output logic                 [DIVISOR_W-1:0] divisor_o
);
  assign bypass_o  = (ratio_i == '0);
  assign mult_o    = bypass_o ? RATIO_W'(1) : ratio_i;
  assign divisor_o = div_sel_i ? DIVISOR_W'(1) : DIVISOR_W'(2);
endmodule

// File: rtl/pll_ratio_seq.sv
module pll_ratio_seq
  import pll_ratio_pkg::*;
#(
  parameter int LOCK_CYCLES = 131072
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 prot_en_i,
  input  logic                 wr_en_i,
  input  logic                 wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  output logic [RATIO_W-1:0]   ratio_o,
  output logic                 bypass_o,
  output logic                 lock_o,
  output logic                 div_sel_o,
  output logic                 wdog_en_o,
  output logic                 err_o,
  output logic [RATIO_W-1:0]   mult_o,
  output logic [DIVISOR_W-1:0] divisor_o
);
  logic start;

  pll_ratio_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .prot_en_i (prot_en_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .lock_i    (lock_o),
    .ratio_o   (ratio_o),
    .div_sel_o (div_sel_o),
    .wdog_en_o (wdog_en_o),
    .err_o     (err_o),
    .start_o   (start)
  );

  pll_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .lock_o  (lock_o)
  );

  pll_ratio_decode u_decode (
    .ratio_i   (ratio_o),
    .div_sel_i (div_sel_o),
    .bypass_o  (bypass_o),
    .mult_o    (mult_o),
    .divisor_o (divisor_o)
  );
endmodule

// File: rtl/pll_ratio_sva.sv
module pll_ratio_sva
  import pll_ratio_pkg::*;
#(
  parameter int LOCK_CYCLES = 131072
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 prot_en_i,
  input logic                 wr_en_i,
  input logic                 wr_addr_i,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic [RATIO_W-1:0]   ratio_o,
  input logic                 lock_o,
  input logic                 div_sel_o,
  input logic                 wdog_en_o,
  input logic                 err_o,
  input logic [RATIO_W-1:0]   mult_o
);
  logic wr_r, good_wr;
  int   since_q;

  assign wr_r    = prot_en_i & wr_en_i & (wr_addr_i == ADDR_RATIO);
  assign good_wr = wr_r & (int'(wr_data_i[RATIO_W-1:0]) <= MAX_CODE) & ~div_sel_o & ~wdog_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        since_q <= LOCK_CYCLES + 1;
    else if (good_wr)                   since_q <= 0;
    else if (since_q <= LOCK_CYCLES)    since_q <= since_q + 1;
  end

  AST_UNPROT_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_en_i |=> $stable(ratio_o) && $stable(div_sel_o) && $stable(wdog_en_o) && $stable(err_o)); // R2
  AST_RESERVED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_r && int'(wr_data_i[RATIO_W-1:0]) > MAX_CODE |=> $stable(ratio_o) && err_o); // R4
  AST_INTERLOCK_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_r && (div_sel_o || wdog_en_o) |=> $stable(ratio_o) && err_o); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R6
  AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_wr |=> !lock_o); // R7
  AST_LOCK_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> since_q == LOCK_CYCLES); // R8
  AST_DIV_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div_sel_o) |-> $past(lock_o)); // R9
  AST_WDOG_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdog_en_o) |-> $past(lock_o)); // R10
  AST_MULT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(mult_o) >= 1 && int'(mult_o) <= MAX_CODE); // R11
endmodule

bind pll_ratio_seq pll_ratio_sva #(.LOCK_CYCLES(LOCK_CYCLES)) u_sva (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .prot_en_i (prot_en_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ratio_o   (ratio_o),
  .lock_o    (lock_o),
  .div_sel_o (div_sel_o),
  .wdog_en_o (wdog_en_o),
  .err_o     (err_o),
  .mult_o    (mult_o)
);

// File: tb/pll_ratio_seq_bench.sv
module pll_ratio_seq_bench;
  localparam int L = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       prot = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [3:0] data = '0;
  logic [3:0] ratio, mult;
  logic [1:0] divisor;
  logic       bypass, lock, div_sel, wdog, err;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string tag = "R1";

  // reference model state
  int m_ratio, m_lock, m_div, m_wdog, m_err, m_cnt, m_busy;

  always #10 clk = ~clk;

  pll_ratio_seq #(.LOCK_CYCLES(L)) u_pll_ratio_seq (
    .clk_i(clk), .rst_ni(rst_n), .prot_en_i(prot), .wr_en_i(wr),
    .wr_addr_i(addr), .wr_data_i(data), .ratio_o(ratio), .bypass_o(bypass),
    .lock_o(lock), .div_sel_o(div_sel), .wdog_en_o(wdog), .err_o(err),
    .mult_o(mult), .divisor_o(divisor)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ratio = 0; m_lock = 1; m_div = 0; m_wdog = 1; m_err = 0; m_cnt = 0; m_busy = 0;
    end else begin
      int old_lock;
      old_lock = m_lock;
      if (m_busy != 0) begin
        if (m_cnt == L - 1) begin m_lock = 1; m_busy = 0; end
        else m_cnt++;
      end
      if (wr && prot) begin
        if (addr == 1'b0) begin
          if (int'(data) > 10 || m_div != 0 || m_wdog != 0) m_err = 1;
          else begin m_ratio = int'(data); m_lock = 0; m_busy = 1; m_cnt = 0; end
        end else begin
          if (!data[0]) m_div = 0; else if (old_lock != 0) m_div = 1;
          if (!data[1]) m_wdog = 0; else if (old_lock != 0) m_wdog = 1;
        end
      end
    end
  end

  task automatic cmp(string name, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, name, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    cmp("ratio", int'(ratio), m_ratio);
    cmp("lock", int'(lock), m_lock);
    cmp("div_sel", int'(div_sel), m_div);
    cmp("wdog_en", int'(wdog), m_wdog);
    cmp("err", int'(err), m_err);
    cmp("bypass", int'(bypass), m_ratio == 0 ? 1 : 0);
    cmp("mult", int'(mult), m_ratio == 0 ? 1 : m_ratio);
    cmp("divisor", int'(divisor), m_div != 0 ? 1 : 2);
  end

  task automatic bus_wr(input logic a, input logic [3:0] d, input logic p);
    @(negedge clk);
    wr = 1'b1; addr = a; data = d; prot = p;
    @(negedge clk);
    wr = 1'b0; prot = 1'b0; data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    tag = "R1"; idle(3);
    tag = "R2"; bus_wr(1'b0, 4'd5, 1'b0); bus_wr(1'b1, 4'd0, 1'b0); idle(2);
    tag = "R10"; bus_wr(1'b1, 4'd0, 1'b1); idle(1);
    tag = "R4"; bus_wr(1'b0, 4'd12, 1'b1); idle(1);
    tag = "R6"; idle(3);
    tag = "R10"; bus_wr(1'b1, 4'd2, 1'b1);
    tag = "R5"; bus_wr(1'b0, 4'd3, 1'b1); bus_wr(1'b1, 4'd0, 1'b1);
    tag = "R3"; bus_wr(1'b0, 4'd7, 1'b1); idle(15);
    tag = "R8"; bus_wr(1'b0, 4'd10, 1'b1);
    tag = "R9"; bus_wr(1'b1, 4'd1, 1'b1);
    tag = "R10"; bus_wr(1'b1, 4'd2, 1'b1);
    tag = "R7"; idle(L + 5);
    tag = "R9"; bus_wr(1'b1, 4'd1, 1'b1);
    tag = "R5"; bus_wr(1'b0, 4'd4, 1'b1);
    tag = "R9"; bus_wr(1'b1, 4'd0, 1'b1);
    tag = "R11";
    for (int k = 0; k <= 10; k++) begin
      bus_wr(1'b0, 4'(k), 1'b1); idle(3);
    end
    tag = "R7"; bus_wr(1'b0, 4'd0, 1'b1); idle(L + 3);
    tag = "R11"; bus_wr(1'b1, 4'd3, 1'b1); idle(3);
    tag = "R2"; bus_wr(1'b1, 4'd0, 1'b0); idle(2);
    tag = "R1"; bus_wr(1'b1, 4'd0, 1'b1); bus_wr(1'b0, 4'd6, 1'b1); idle(5);
    rst_n = 1'b0; idle(2); rst_n = 1'b1; idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule